// File: doc/BRIEF.md
# PCI Express Configuration Window Base Decoder

This block holds one 64-bit host-bridge register. The register says whether the memory-mapped PCI Express configuration window is on, how large it is, and where it sits in the address space. Software writes the register through a byte-enabled configuration write port. The block decodes the stored value into a window descriptor: an enable flag, a length code, a size in bytes and a base address. The base is masked so that it is aligned to the chosen size.

The descriptor drives a registered hit output. A probe address that falls inside an enabled window raises the hit output one clock later. The descriptor is recomputed on every write that touches at least one byte, and again at reset. If the written value carries the reserved length code, the window that was last applied stays in force. The raw register still takes the written bytes.

Top module: `cfgwin_decoder`

## Requirements
- R1: Synchronous active-high reset loads the register with RESET_VALUE (default 64'h0000_0000_B000_0000). The descriptor then shows enable 0, length code 00, size 256 MiB and base 0xB000_0000, and probe_hit is 0.
- R2: A write changes only the bytes whose wr_be bit is set (bit k covers data bits 8k+7:8k). A write with wr_be all zero leaves cfg_q unchanged.
- R3: Register bit 0 is the window enable and appears on win_enable.
- R4: Register bits 2:1 are the length code: 00 selects 256 MiB (2^28), 01 selects 128 MiB (2^27), 10 selects 64 MiB (2^26). win_len carries the size in bytes.
- R5: win_base is register bits 35:28 for 256 MiB, bits 35:27 for 128 MiB and bits 35:26 for 64 MiB, with every other bit forced to zero. Register bits 25:3 and 63:36 never affect the descriptor.
- R6: A write that leaves length code 11 in the register keeps the applied descriptor unchanged, while cfg_q still takes the written bytes.
- R7: A write with a legal length code updates the descriptor at the same clock edge that updates the register.
- R8: probe_hit rises one clock after a probe_addr is presented when the window is enabled and base <= probe_addr < base + size. Any probe_addr bit above bit 35 that is set means no hit.
- R9: A disabled window never produces a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Configuration write strobe |
| wr_be | input | 8 | Byte enables for the write |
| wr_data | input | 64 | Write data |
| probe_addr | input | ADDR_W | Address tested against the window |
| cfg_q | output | 64 | Stored register value |
| win_enable | output | 1 | Applied window enable |
| win_code | output | 2 | Applied length code |
| win_len | output | ADDR_W | Applied window size in bytes |
| win_base | output | ADDR_W | Applied, size-aligned window base |
| probe_hit | output | 1 | Registered hit for the previous probe_addr |

## Verification
The hardest state to reach is a stored register whose contents differ from the applied descriptor. It only arises after a write that lands the reserved length code in the register. The stimulus first applies an enabled 64 MiB window. It then rewrites only the low byte with code 11, and checks three things: the descriptor, a probe hit at the old base, and the raw register, which shows the new byte. Further single-byte writes then build up base values field by field. This shows that lower-order base bits enter or leave the base as the length code changes.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
   // Register field positions that the decoder depends on
   localparam int EN_POS  = 0;
   localparam int LEN_LSB = 1;
   localparam int LEN_MSB = 2;
   // Length code values
   localparam logic [1:0] LEN_CODE_256 = 2'b00;
   localparam logic [1:0] LEN_CODE_128 = 2'b01;
   localparam logic [1:0] LEN_CODE_64  = 2'b10;
   localparam logic [1:0] LEN_RSVD     = 2'b11;
   // Number of legal window sizes
   localparam int NUM_SIZES = 3;
endpackage

// File: rtl/cfgwin_reg.sv
module cfgwin_reg #(
   parameter int          REG_BYTES   = 8,
   parameter logic [63:0] RESET_VALUE = 64'h0
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   wr_en,
   input  logic [REG_BYTES-1:0]   wr_be,
   input  logic [REG_BYTES*8-1:0] wr_data,
   output logic [REG_BYTES*8-1:0] cfg_q,
   output logic [REG_BYTES*8-1:0] cfg_next,
   output logic                   wr_fire
);
   assign wr_fire = wr_en && (|wr_be);

   for (genvar k = 0; k < REG_BYTES; k++) begin : g_lane
      logic sel;
      assign sel = wr_en && wr_be[k];
      assign cfg_next[8*k +: 8] = sel ? wr_data[8*k +: 8] : cfg_q[8*k +: 8];

      always_ff @(posedge clk) begin
         if (rst) cfg_q[8*k +: 8] <= RESET_VALUE[8*k +: 8];
         else if (sel) cfg_q[8*k +: 8] <= wr_data[8*k +: 8];
      end

      // R2
      lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
         !wr_be[k] |=> $stable(cfg_q[8*k +: 8]));
   end
endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
   import cfgwin_pkg::*;
#(
   parameter int ADDR_W  = 40,
   parameter int BASE_HI = 35,
   parameter int MAX_LG  = 28
) (
   input  logic [BASE_HI:0]   cfg_i,
   output logic               en_o,
   output logic [1:0]         code_o,
   output logic [ADDR_W-1:0]  len_o,
   output logic [ADDR_W-1:0]  base_o
);
   localparam logic [ADDR_W-1:0] FIELD_MASK = {ADDR_W{1'b1}} >> (ADDR_W - 1 - BASE_HI);

   logic [ADDR_W-1:0] size_tab [NUM_SIZES];
   logic [ADDR_W-1:0] mask_tab [NUM_SIZES];

   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
      localparam int SH = MAX_LG - k;
      assign size_tab[k] = ADDR_W'(1) << SH;
      assign mask_tab[k] = FIELD_MASK & ({ADDR_W{1'b1}} << SH);
   end

   logic [ADDR_W-1:0] sel_mask;

   assign en_o   = cfg_i[EN_POS];
   assign code_o = cfg_i[LEN_MSB:LEN_LSB];

   always_comb begin
      len_o    = '0;
      sel_mask = '0;
      for (int i = 0; i < NUM_SIZES; i++) begin
         if (code_o == i[1:0]) begin
            len_o    = size_tab[i];
            sel_mask = mask_tab[i];
         end
      end
   end

   assign base_o = ADDR_W'(cfg_i) & sel_mask;
endmodule

// File: rtl/cfgwin_apply.sv
module cfgwin_apply
   import cfgwin_pkg::*;
#(
   parameter int ADDR_W = 40
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              upd_i,
   input  logic              en_i,
   input  logic [1:0]        code_i,
   input  logic [ADDR_W-1:0] len_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              dflt_en,
   input  logic [1:0]        dflt_code,
   input  logic [ADDR_W-1:0] dflt_len,
   input  logic [ADDR_W-1:0] dflt_base,
   output logic              en_o,
   output logic [1:0]        code_o,
   output logic [ADDR_W-1:0] len_o,
   output logic [ADDR_W-1:0] base_o
);
   logic take;
   assign take = upd_i && (code_i != LEN_RSVD);

   always_ff @(posedge clk) begin
      if (rst) begin
         en_o   <= dflt_en;
         code_o <= dflt_code;
         len_o  <= dflt_len;
         base_o <= dflt_base;
      end else if (take) begin
         en_o   <= en_i;
         code_o <= code_i;
         len_o  <= len_i;
         base_o <= base_i;
      end
   end

   // R6
   rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (upd_i && code_i == LEN_RSVD) |=> ($stable(base_o) && $stable(len_o) && $stable(en_o) && $stable(code_o)));

   // R7
   apply_new_chk: assert property (@(posedge clk) disable iff (rst)
      (upd_i && code_i != LEN_RSVD) |=> (base_o == $past(base_i) && len_o == $past(len_i) && en_o == $past(en_i)));
endmodule

// File: rtl/cfgwin_hit.sv
module cfgwin_hit #(
   parameter int ADDR_W = 40
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              en_i,
   input  logic [ADDR_W-1:0] len_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              hit_o
);
   logic [ADDR_W-1:0] blk_mask;
   assign blk_mask = ~(len_i - ADDR_W'(1));

   always_ff @(posedge clk) begin
      if (rst) hit_o <= 1'b0;
      else     hit_o <= en_i && ((addr_i & blk_mask) == base_i);
   end

   // R9
   hit_en_chk: assert property (@(posedge clk) disable iff (rst)
      hit_o |-> $past(en_i));
endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
   import cfgwin_pkg::*;
#(
   parameter int          ADDR_W      = 40,
   parameter int          BASE_HI     = 35,
   parameter int          MAX_LG      = 28,
   parameter logic [63:0] RESET_VALUE = 64'h0000_0000_B000_0000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [7:0]        wr_be,
   input  logic [63:0]       wr_data,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic [63:0]       cfg_q,
   output logic              win_enable,
   output logic [1:0]        win_code,
   output logic [ADDR_W-1:0] win_len,
   output logic [ADDR_W-1:0] win_base,
   output logic              probe_hit
);
   localparam int REG_BYTES = 8;
   localparam int MIN_LG    = MAX_LG - NUM_SIZES + 1;

   if (ADDR_W > 64 || ADDR_W <= BASE_HI) begin : g_bad_addr
      $error("cfgwin_decoder: ADDR_W must exceed BASE_HI and be at most 64");
   end
   if (MIN_LG <= LEN_MSB || MAX_LG > BASE_HI) begin : g_bad_lg
      $error("cfgwin_decoder: size range collides with the control fields or base");
   end
   if (RESET_VALUE[LEN_MSB:LEN_LSB] == LEN_RSVD) begin : g_bad_rst
      $error("cfgwin_decoder: RESET_VALUE holds the reserved length code");
   end

   logic [63:0] cfg_next;
   logic        wr_fire;

   cfgwin_reg #(.REG_BYTES(REG_BYTES), .RESET_VALUE(RESET_VALUE)) u_reg (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
      .cfg_q(cfg_q), .cfg_next(cfg_next), .wr_fire(wr_fire)
   );

   logic              nx_en,  df_en;
   logic [1:0]        nx_code, df_code;
   logic [ADDR_W-1:0] nx_len, nx_base, df_len, df_base;

   cfgwin_decode #(.ADDR_W(ADDR_W), .BASE_HI(BASE_HI), .MAX_LG(MAX_LG)) u_dec_next (
      .cfg_i(cfg_next[BASE_HI:0]), .en_o(nx_en), .code_o(nx_code),
      .len_o(nx_len), .base_o(nx_base)
   );

   cfgwin_decode #(.ADDR_W(ADDR_W), .BASE_HI(BASE_HI), .MAX_LG(MAX_LG)) u_dec_dflt (
      .cfg_i(RESET_VALUE[BASE_HI:0]), .en_o(df_en), .code_o(df_code),
      .len_o(df_len), .base_o(df_base)
   );

   cfgwin_apply #(.ADDR_W(ADDR_W)) u_apply (
      .clk(clk), .rst(rst), .upd_i(wr_fire),
      .en_i(nx_en), .code_i(nx_code), .len_i(nx_len), .base_i(nx_base),
      .dflt_en(df_en), .dflt_code(df_code), .dflt_len(df_len), .dflt_base(df_base),
      .en_o(win_enable), .code_o(win_code), .len_o(win_len), .base_o(win_base)
   );

   cfgwin_hit #(.ADDR_W(ADDR_W)) u_hit (
      .clk(clk), .rst(rst), .addr_i(probe_addr), .en_i(win_enable),
      .len_i(win_len), .base_i(win_base), .hit_o(probe_hit)
   );

   // R4
   len_pow2_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(win_len) == 1);

   // R5
   base_align_chk: assert property (@(posedge clk) disable iff (rst)
      (win_base & (win_len - ADDR_W'(1))) == '0);

   // R3
   win_en_src_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_fire && cfg_next[LEN_MSB:LEN_LSB] != LEN_RSVD) |=> win_enable == cfg_q[EN_POS]);
endmodule

// File: tb/cfgwin_decoder_test.sv
module cfgwin_decoder_test;
   localparam int AW = 40;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_be = '0;
   logic [63:0]   wr_data = '0;
   logic [AW-1:0] probe_addr = '0;
   logic [63:0]   cfg_q;
   logic          win_enable;
   logic [1:0]    win_code;
   logic [AW-1:0] win_len;
   logic [AW-1:0] win_base;
   logic          probe_hit;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   cfgwin_decoder uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
      .probe_addr(probe_addr), .cfg_q(cfg_q), .win_enable(win_enable),
      .win_code(win_code), .win_len(win_len), .win_base(win_base),
      .probe_hit(probe_hit)
   );

   localparam int NV = 7;
   localparam logic [63:0] VDATA [NV] = '{
      64'h0000_0000_E000_0001, 64'h0000_0000_E800_0003, 64'h0000_0000_EC00_0005,
      64'h0000_0000_EC00_0001, 64'hFFFF_FFF8_CFFF_FFFA, 64'h0000_0000_1000_0007,
      64'h0000_0000_1000_0001 };
   localparam bit VEN [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
   localparam int VLG [NV] = '{28, 27, 26, 28, 27, 27, 28};
   localparam logic [AW-1:0] VBASE [NV] = '{
      40'h00_E000_0000, 40'h00_E800_0000, 40'h00_EC00_0000, 40'h00_E000_0000,
      40'h08_C800_0000, 40'h08_C800_0000, 40'h00_1000_0000 };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic write(input logic [7:0] be, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_be = be; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_be = '0;
   endtask

   task automatic probe(input logic [AW-1:0] a, input bit exp, input string req);
      @(negedge clk);
      probe_addr = a;
      @(negedge clk);
      check(req, 64'(probe_hit), 64'(exp));
   endtask

   task automatic check_win(input string req, input bit en, input int lg, input logic [AW-1:0] base);
      check({req, " enable"}, 64'(win_enable), 64'(en));
      check({req, " size"}, 64'(win_len), 64'(40'(1) << lg));
      check({req, " base"}, 64'(win_base), 64'(base));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R8 watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check("R1 cfg", cfg_q, 64'h0000_0000_B000_0000);
      check_win("R1", 1'b0, 28, 40'h00_B000_0000);
      check("R1 code", 64'(win_code), 64'(2'b00));
      check("R1 hit", 64'(probe_hit), 64'd0);
      probe(40'h00_B000_0000, 1'b0, "R9 default disabled");

      // Table of full-width writes: R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         write(8'hFF, VDATA[i]);
         check("R6 cfg stored", cfg_q, VDATA[i]);
         check_win("R7 R4 R5 R3 vector", VEN[i], VLG[i], VBASE[i]);
         probe(VBASE[i] + (40'(1) << VLG[i]) - 40'(1), VEN[i], "R8 top byte");
         probe(VBASE[i] + (40'(1) << VLG[i]), 1'b0, "R8 past end");
         probe(VBASE[i] - 40'(1), 1'b0, "R8 below base");
      end

      // R2 single byte lane
      write(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
      check("R2 lane3", cfg_q, 64'h0000_0000_FF00_0001);
      check_win("R2", 1'b1, 28, 40'h00_F000_0000);
      // R2 no byte enables
      write(8'h00, 64'h0);
      check("R2 no lanes", cfg_q, 64'h0000_0000_FF00_0001);
      // R5 base bits above 31
      write(8'h10, 64'h0000_000A_0000_0000);
      check("R2 lane4", cfg_q, 64'h0000_000A_FF00_0001);
      check_win("R5 high base", 1'b1, 28, 40'h0A_F000_0000);
      probe(40'h0A_F000_0000, 1'b1, "R8 at base");
      probe(40'h1A_F000_0000, 1'b0, "R8 upper address bit");
      // R4/R5 switch to 64 MiB brings bits 27:26 in
      write(8'h01, 64'h05);
      check_win("R5 64MiB", 1'b1, 26, 40'h0A_FC00_0000);
      check("R4 code", 64'(win_code), 64'(2'b10));
      probe(40'h0A_FC00_0000, 1'b1, "R8 64MiB base");
      probe(40'h0A_F000_0000, 1'b0, "R8 outside 64MiB");
      // R6 reserved code keeps the applied window
      write(8'h01, 64'h07);
      check("R6 cfg", cfg_q, 64'h0000_000A_FF00_0007);
      check_win("R6 held", 1'b1, 26, 40'h0A_FC00_0000);
      check("R6 code", 64'(win_code), 64'(2'b10));
      probe(40'h0A_FC00_0000, 1'b1, "R6 old window hit");
      // R9 disabled window
      write(8'h01, 64'h00);
      check_win("R9", 1'b0, 28, 40'h0A_F000_0000);
      probe(40'h0A_F000_0000, 1'b0, "R9 disabled");
      // R1 reset mid-run
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 cfg again", cfg_q, 64'h0000_0000_B000_0000);
      check_win("R1 again", 1'b0, 28, 40'h00_B000_0000);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule